// File: doc/BRIEF.md
# Packed Subword SIMD Arithmetic Unit

This unit is the arithmetic slice of a signal-processing core. It takes two 32-bit source words, an operation code and a lane-mode code. It returns a 64-bit registered result one clock after the input strobe. Addition and subtraction run on one segmented adder. In whole-word mode the adder works as a single 32-bit lane, and its sum is widened to 40 bits so that a running accumulation keeps the bits that overflow past bit 31. In the two packed modes the same adder is cut into two 16-bit lanes or four 8-bit lanes. Carries are blocked at every lane edge, so each lane wraps on its own.

Multiplication is signed and lane-parallel. The dual-halfword mode gives two 32-bit products. The quad-byte mode gives four 16-bit products. In both modes the products are packed with lane 0 in the lowest bits. The result register loads only on a strobed input. A valid flag marks the cycle in which a new result is present.

Operation codes: 2'b00 add, 2'b01 subtract, 2'b10 multiply, 2'b11 reserved. Lane-mode codes: 2'b00 one 32-bit lane, 2'b01 two 16-bit lanes, 2'b10 four 8-bit lanes, 2'b11 reserved.

Top module: `simd_arith_unit`

## Requirements
- R1: While rst_n is low, out_valid is 0 and result is all zeros.
- R2: out_valid equals in_valid delayed by one clock. result loads on a clock edge only when in_valid is high. Otherwise it keeps its value.
- R3: Op 2'b00 with lane mode 2'b00 gives result[39:0] = sign-extended src_a + sign-extended src_b, both extended to 40 bits. result[63:40] is zero.
- R4: Op 2'b01 with lane mode 2'b00 gives result[39:0] = sign-extended src_a - sign-extended src_b, both extended to 40 bits. result[63:40] is zero.
- R5: Op 2'b00 or 2'b01 with lane mode 2'b01 gives result[16k+15:16k] = src_a[16k+15:16k] ± src_b[16k+15:16k] modulo 2^16, for k = 0 and 1. No carry or borrow passes between the lanes, and result[63:32] is zero.
- R6: Op 2'b00 or 2'b01 with lane mode 2'b10 gives result[8k+7:8k] = src_a lane k ± src_b lane k modulo 2^8, for k = 0 to 3. No carry or borrow passes between the lanes, and result[63:32] is zero.
- R7: Op 2'b10 with lane mode 2'b01 gives result[32k+31:32k] = the signed product of src_a[16k+15:16k] and src_b[16k+15:16k], for k = 0 and 1.
- R8: Op 2'b10 with lane mode 2'b10 gives result[16k+15:16k] = the signed product of src_a[8k+7:8k] and src_b[8k+7:8k], for k = 0 to 3.
- R9: Op 2'b11 gives an all-zero result in every lane mode. out_valid still follows R2.
- R10: Lane mode 2'b11 with any op, and op 2'b10 with lane mode 2'b00, give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; loads the result register |
| op | input | 2 | Operation code |
| lane_mode | input | 2 | Lane partition code |
| src_a | input | 32 | First packed operand |
| src_b | input | 32 | Second packed operand |
| out_valid | output | 1 | High one clock after a strobed input |
| result | output | 64 | Registered packed result |

## Verification
If a lane-start decision is wrong inside the segmented adder, a carry or borrow leaks into the next lane or is dropped. The damage shows up on the very next result as an off-by-one in a lane above the boundary. Operands such as all-ones and 0x80 or 0x8000 patterns make this visible at every lane edge. A wrong hold enable shows up in the first idle cycle after a strobe, when result changes or out_valid stays high. A faulty multiplier sign or lane placement corrupts the packed product in that same cycle.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_RSV = 2'b11
    } arith_op_e;

    typedef enum logic [1:0] {
        LM_WORD = 2'b00,
        LM_HALF = 2'b01,
        LM_BYTE = 2'b10,
        LM_RSV  = 2'b11
    } lane_mode_e;

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
    import simd_pkg::*;
#(
    parameter int SEG_W = 8,
    parameter int NSEG  = 4,
    parameter int EXT_W = 8,
    localparam int DW   = SEG_W * NSEG
) (
    input  logic [DW-1:0]       a,
    input  logic [DW-1:0]       b,
    input  logic                sub,
    input  lane_mode_e          mode,
    output logic [DW+EXT_W-1:0] sum
);
    logic [DW-1:0] bx;
    logic [NSEG:0] carry;
    logic [NSEG-1:0] seg_start;
    logic [EXT_W-1:0] ext;

    assign bx = sub ? ~b : b;
    assign carry[0] = sub;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam bit HALF_EDGE = ((i % 2) == 0);
        logic cin;
        logic [SEG_W:0] seg_sum;

        always_comb begin
            unique case (mode)
                LM_WORD: seg_start[i] = (i == 0);
                LM_HALF: seg_start[i] = HALF_EDGE;
                LM_BYTE: seg_start[i] = 1'b1;
                LM_RSV:  seg_start[i] = 1'b1;
            endcase
        end

        assign cin = seg_start[i] ? sub : carry[i];
        assign seg_sum = {1'b0, a[i*SEG_W +: SEG_W]}
                       + {1'b0, bx[i*SEG_W +: SEG_W]}
                       + {{SEG_W{1'b0}}, cin};
        assign carry[i+1] = seg_sum[SEG_W];
        assign sum[i*SEG_W +: SEG_W] = seg_sum[SEG_W-1:0];
    end

    assign ext = {EXT_W{a[DW-1]}} + {EXT_W{bx[DW-1]}}
               + {{(EXT_W-1){1'b0}}, carry[NSEG]};
    assign sum[DW +: EXT_W] = (mode == LM_WORD) ? ext : '0;
endmodule

// File: rtl/simd_lane_mul.sv
module simd_lane_mul
    import simd_pkg::*;
#(
    parameter int SEG_W = 8,
    parameter int NSEG  = 4,
    localparam int DW   = SEG_W * NSEG,
    localparam int RW   = 2 * DW,
    localparam int HW   = 2 * SEG_W,
    localparam int NHALF = NSEG / 2
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  lane_mode_e    mode,
    output logic [RW-1:0] prod
);
    logic [RW-1:0] byte_prod;
    logic [RW-1:0] half_prod;

    for (genvar i = 0; i < NSEG; i++) begin : g_byte
        logic signed [SEG_W-1:0] x, y;
        logic signed [HW-1:0]    p;
        assign x = a[i*SEG_W +: SEG_W];
        assign y = b[i*SEG_W +: SEG_W];
        assign p = x * y;
        assign byte_prod[i*HW +: HW] = p;
    end

    for (genvar j = 0; j < NHALF; j++) begin : g_half
        logic signed [HW-1:0]   x, y;
        logic signed [2*HW-1:0] p;
        assign x = a[j*HW +: HW];
        assign y = b[j*HW +: HW];
        assign p = x * y;
        assign half_prod[j*2*HW +: 2*HW] = p;
    end

    always_comb begin
        unique case (mode)
            LM_HALF: prod = half_prod;
            LM_BYTE: prod = byte_prod;
            LM_WORD: prod = '0;
            LM_RSV:  prod = '0;
        endcase
    end
endmodule

// File: rtl/simd_arith_unit.sv
module simd_arith_unit
    import simd_pkg::*;
#(
    parameter int SEG_W = 8,
    parameter int NSEG  = 4,
    parameter int EXT_W = 8,
    localparam int DW   = SEG_W * NSEG,
    localparam int RW   = 2 * DW,
    localparam int AW   = DW + EXT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [1:0]    op,
    input  logic [1:0]    lane_mode,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic          out_valid,
    output logic [RW-1:0] result
);
    arith_op_e  op_e;
    lane_mode_e mode_e;
    logic [AW-1:0] add_sum;
    logic [RW-1:0] mul_prod;
    logic [RW-1:0] next_result;

    assign op_e   = arith_op_e'(op);
    assign mode_e = lane_mode_e'(lane_mode);

    simd_seg_adder #(.SEG_W(SEG_W), .NSEG(NSEG), .EXT_W(EXT_W)) u_add (
        .a(src_a), .b(src_b), .sub(op_e == OP_SUB), .mode(mode_e), .sum(add_sum)
    );

    simd_lane_mul #(.SEG_W(SEG_W), .NSEG(NSEG)) u_mul (
        .a(src_a), .b(src_b), .mode(mode_e), .prod(mul_prod)
    );

    always_comb begin
        next_result = '0;
        unique case (op_e)
            OP_ADD, OP_SUB: if (mode_e != LM_RSV) next_result = {{(RW-AW){1'b0}}, add_sum};
            OP_MUL:         next_result = mul_prod;
            OP_RSV:         next_result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_result;
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    assert_reserved_op_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=> (result == '0));
    assert_word_top_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op[1] && lane_mode == 2'b00) |=> (result[RW-1:AW] == '0));
    assert_half_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op[1] && lane_mode == 2'b01) |=> (result[RW-1:DW] == '0));
    assert_byte_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op[1] && lane_mode == 2'b10) |=> (result[RW-1:DW] == '0));
endmodule

// File: tb/simd_arith_unit_test.sv
`timescale 1ns/1ps
module simd_arith_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [1:0]  lane_mode = 2'b00;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    logic [31:0] lfsr = 32'h1234_5678;
    logic [63:0] last_exp = '0;

    always #2 clk = ~clk;

    simd_arith_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_mode(lane_mode),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [1:0] o, input logic [1:0] m,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [63:0] r;
        logic [39:0] s;
        r = '0;
        if (m == 2'b11 || o == 2'b11) return '0;
        if (o != 2'b10) begin
            if (m == 2'b00) begin
                if (o == 2'b00) s = {{8{a[31]}}, a} + {{8{b[31]}}, b};
                else            s = {{8{a[31]}}, a} - {{8{b[31]}}, b};
                r[39:0] = s;
            end else if (m == 2'b01) begin
                for (int k = 0; k < 2; k++)
                    r[16*k +: 16] = (o == 2'b00) ? a[16*k +: 16] + b[16*k +: 16]
                                                 : a[16*k +: 16] - b[16*k +: 16];
            end else begin
                for (int k = 0; k < 4; k++)
                    r[8*k +: 8] = (o == 2'b00) ? a[8*k +: 8] + b[8*k +: 8]
                                               : a[8*k +: 8] - b[8*k +: 8];
            end
        end else if (m == 2'b01) begin
            for (int k = 0; k < 2; k++) begin
                logic signed [15:0] x, y;
                logic signed [31:0] p;
                x = a[16*k +: 16]; y = b[16*k +: 16]; p = x * y;
                r[32*k +: 32] = p;
            end
        end else if (m == 2'b10) begin
            for (int k = 0; k < 4; k++) begin
                logic signed [7:0]  x, y;
                logic signed [15:0] p;
                x = a[8*k +: 8]; y = b[8*k +: 8]; p = x * y;
                r[16*k +: 16] = p;
            end
        end
        return r;
    endfunction

    function automatic string tag(input logic [1:0] o, input logic [1:0] m);
        if (o == 2'b11) return "R9";
        if (m == 2'b11 || (o == 2'b10 && m == 2'b00)) return "R10";
        if (o == 2'b10) return (m == 2'b01) ? "R7" : "R8";
        if (m == 2'b00) return (o == 2'b00) ? "R3" : "R4";
        return (m == 2'b01) ? "R5" : "R6";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [1:0] m,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1; op = o; lane_mode = m; src_a = a; src_b = b;
        last_exp = model(o, m, a, b);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", {63'b0, out_valid}, 64'd1);
        check(tag(o, m), result, last_exp);
    endtask

    task automatic idle_check(input logic [31:0] a, input logic [31:0] b);
        op = 2'b00; lane_mode = 2'b00; src_a = a; src_b = b; in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2 hold", result, last_exp);
        check("R2 idle valid", {63'b0, out_valid}, 64'd0);
    endtask

    function automatic logic [31:0] corner(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h80FF_7F01;
            5: return 32'h7F80_8000;
            default: return 32'h00FF_FF00;
        endcase
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", {63'b0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
        in_valid = 1'b1; src_a = 32'hFFFF_FFFF; src_b = 32'h1;
        @(posedge clk);
        @(negedge clk);
        check("R1 valid under strobe", {63'b0, out_valid}, 64'd0);
        check("R1 result under strobe", result, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int o = 0; o < 4; o++)
            for (int m = 0; m < 4; m++) begin
                for (int i = 0; i < 7; i++)
                    for (int j = 0; j < 7; j++)
                        apply(o[1:0], m[1:0], corner(i), corner(j));
                for (int n = 0; n < 24; n++) begin
                    logic [31:0] a;
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    a = lfsr;
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    apply(o[1:0], m[1:0], a, lfsr);
                end
                idle_check(32'h1234_5678, 32'h0F0F_0F0F);
            end

        apply(2'b00, 2'b01, 32'h0000_FFFF, 32'h0000_0001);
        check("R5 no carry into upper half", result, 64'h0);
        apply(2'b01, 2'b10, 32'h0000_0000, 32'h0000_0001);
        check("R6 no borrow across bytes", result, 64'h0000_0000_0000_00FF);
        apply(2'b00, 2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        check("R3 extended sum", result, 64'h0000_0000_FFFF_FFFE);
        apply(2'b01, 2'b00, 32'h8000_0000, 32'h0000_0001);
        check("R4 extended diff", result, 64'h0000_00FF_7FFF_FFFF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule